// File: doc/BRIEF.md
# Delayed Register Update Queue

This block holds register writes that must land some number of ticks after they are issued, the way results from a load path or a coprocessor pipeline reach the register file late. A producer pushes an update that carries a destination register id, a delay in ticks, a 64-bit value, a bit index, a flag that selects a whole-register write instead of a single-bit write, and a width flag that picks 32 or 64 bits. The entries sit in a circular buffer of a fixed number of slots. Each slot counts down on its own on every tick pulse. When a slot runs out, the block presents one masked write on its write port. For a single-bit update it sets or clears just that bit. For a whole-register update it writes the full value across the selected width.

The write port carries a byte-free bit mask and the matching data. The register file only has to do `reg = (reg & ~mask) | (data & mask)`, and needs no read path back into this block. Expired slots are served one per clock, in queue order starting at the head. A slot behind the head that has already been served is marked done and is not served again. It frees its storage only once the head pointer reaches it.

Top module: `delayed_update_queue`

## Requirements
- R1: After reset the queue is empty: `enq_full` is 0, `wr_en` is 0 and `err` is 0.
- R2: An enqueue is accepted while fewer than SLOTS entries are held, and `enq_full` is 1 exactly when SLOTS entries are held. An enqueue while full is dropped and never produces a write.
- R3: An entry enqueued with delay D ≥ 1 presents its write in the cycle after the posedge that takes its D-th tick pulse. A delay of 0 behaves like 1. Cycles without a tick do not count.
- R4: A single-bit update (`enq_whole`=0) with a nonzero value gives `wr_mask` = `wr_data` = 1 << bit.
- R5: A single-bit update with value 0 gives `wr_mask` = 1 << bit and `wr_data` = 0, so every other bit of the destination is left unchanged.
- R6: A whole update (`enq_whole`=1) with `enq_wide`=1 gives `wr_mask` of all ones and `wr_data` = value. With `enq_wide`=0 it gives `wr_mask` = 0x00000000FFFFFFFF and `wr_data` = value[31:0], zero-extended.
- R7: For a 32-bit single-bit update only the low five bits of the bit index are used. For a 64-bit one all six bits are used.
- R8: Slots that expire on the same tick are presented one per cycle, in queue order from the head.
- R9: Each entry is presented exactly once. Its storage is freed, which clears `enq_full`, only when it is the head. Retirement is at most one slot per cycle.
- R10: `err` flags in/out pointers that differ while the held count is zero. It never rises during correct operation, including after the pointers wrap.
- R11: `wr_dest` equals the destination id given when the presented entry was enqueued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Countdown pulse, one decrement per cycle high |
| enq_valid | input | 1 | Push an update |
| enq_dest | input | ID_W | Destination register id |
| enq_delay | input | DLY_W | Ticks before the update lands |
| enq_value | input | 64 | Value (whole) or set/clear selector (bit) |
| enq_bit | input | 6 | Bit index for single-bit updates |
| enq_whole | input | 1 | 1 = whole-register write, 0 = single bit |
| enq_wide | input | 1 | 1 = 64-bit register, 0 = 32-bit |
| enq_full | output | 1 | All slots held; pushes are dropped |
| wr_en | output | 1 | Write port valid this cycle |
| wr_dest | output | ID_W | Write destination id |
| wr_mask | output | 64 | Bits to be changed |
| wr_data | output | 64 | New values for masked bits |
| err | output | 1 | Pointer/count consistency fault |

## Verification
The hardest state to reach from the ports is an entry behind the head that has expired and been served while the head is still counting. That state must hold without a second write, and its slot must stay occupied until the head retires. The bench fills all four slots so that the head has the longest delay and two later slots share the shortest one. It then drains with separate tick pulses and checks the order of the writes, that no write repeats, and the exact cycle in which `enq_full` falls. A push made while full, with a one-tick delay, must never show up on the write port. Refilling after the drain drives the pointers across the wrap.

// File: rtl/delayed_update_queue.sv
module delayed_update_queue #(
  parameter int SLOTS = 4,
  parameter int ID_W  = 5,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enq_valid,
  input  logic [ID_W-1:0]  enq_dest,
  input  logic [DLY_W-1:0] enq_delay,
  input  logic [63:0]      enq_value,
  input  logic [5:0]       enq_bit,
  input  logic             enq_whole,
  input  logic             enq_wide,
  output logic             enq_full,
  output logic             wr_en,
  output logic [ID_W-1:0]  wr_dest,
  output logic [63:0]      wr_mask,
  output logic [63:0]      wr_data,
  output logic             err
);
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [SLOTS-1:0] s_valid, s_exp, s_done, s_whole, s_wide;
  logic [DLY_W-1:0] s_cnt  [SLOTS];
  logic [ID_W-1:0]  s_dest [SLOTS];
  logic [63:0]      s_val  [SLOTS];
  logic [5:0]       s_bit  [SLOTS];

  logic [PTR_W-1:0] in_ptr, out_ptr, cand;
  logic [CNT_W-1:0] total;
  logic             found, accept, retire;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (int'(p) == SLOTS - 1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    found = 1'b0;
    cand  = out_ptr;
    for (int k = 0; k < SLOTS; k++) begin
      int j;
      j = (int'(out_ptr) + k) % SLOTS;
      if (!found && s_valid[j] && s_exp[j] && !s_done[j]) begin
        found = 1'b1;
        cand  = PTR_W'(j);
      end
    end
  end

  assign enq_full = (total == CNT_W'(SLOTS));
  assign accept   = enq_valid && !enq_full;
  assign retire   = s_valid[out_ptr] && (s_done[out_ptr] || (found && cand == out_ptr));
  assign err      = (in_ptr != out_ptr) && (total == '0);

  logic [63:0] width_mask, one_hot;
  logic [5:0]  bit_idx;
  assign width_mask = s_wide[cand] ? '1 : 64'h0000_0000_FFFF_FFFF;
  assign bit_idx    = s_wide[cand] ? s_bit[cand] : {1'b0, s_bit[cand][4:0]};
  assign one_hot    = 64'd1 << bit_idx;

  assign wr_en   = found;
  assign wr_dest = s_dest[cand];
  assign wr_mask = s_whole[cand] ? width_mask : one_hot;
  assign wr_data = s_whole[cand] ? (s_val[cand] & width_mask)
                                 : ((|s_val[cand]) ? one_hot : 64'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid <= '0;
      s_exp   <= '0;
      s_done  <= '0;
      in_ptr  <= '0;
      out_ptr <= '0;
      total   <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (tick && s_valid[i] && !s_exp[i]) begin
          if (s_cnt[i] <= DLY_W'(1)) begin
            s_exp[i] <= 1'b1;
            s_cnt[i] <= '0;
          end else begin
            s_cnt[i] <= s_cnt[i] - 1'b1;
          end
        end
      end
      if (found && cand != out_ptr) s_done[cand] <= 1'b1;
      if (retire) begin
        s_valid[out_ptr] <= 1'b0;
        out_ptr          <= next_ptr(out_ptr);
      end
      if (accept) begin
        s_valid[in_ptr] <= 1'b1;
        s_exp[in_ptr]   <= 1'b0;
        s_done[in_ptr]  <= 1'b0;
        s_cnt[in_ptr]   <= enq_delay;
        s_dest[in_ptr]  <= enq_dest;
        s_val[in_ptr]   <= enq_value;
        s_bit[in_ptr]   <= enq_bit;
        s_whole[in_ptr] <= enq_whole;
        s_wide[in_ptr]  <= enq_wide;
        in_ptr          <= next_ptr(in_ptr);
      end
      total <= total + CNT_W'(accept) - CNT_W'(retire);
    end
  end

  p_held_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(total) <= SLOTS);

  p_full_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_full && enq_valid) |=> (total <= $past(total)));

  p_one_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'($past(total)) <= int'(total) + 1);

  p_single_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !s_whole[cand]) |-> ($countones(wr_mask) == 1));

  p_data_in_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data & ~wr_mask) == 64'd0));

  p_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n) !err);
endmodule

// File: tb/tb_delayed_update_queue.sv
module tb_delayed_update_queue;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 4;
  localparam int ID_W  = 5;
  localparam int DLY_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, enq_valid = 1'b0;
  logic [ID_W-1:0] enq_dest = '0;
  logic [DLY_W-1:0] enq_delay = '0;
  logic [63:0] enq_value = '0;
  logic [5:0] enq_bit = '0;
  logic enq_whole = 1'b0, enq_wide = 1'b0;
  logic enq_full, wr_en, err;
  logic [ID_W-1:0] wr_dest;
  logic [63:0] wr_mask, wr_data;

  int checks = 0, fails = 0, cycles = 0;

  delayed_update_queue #(.SLOTS(SLOTS), .ID_W(ID_W), .DLY_W(DLY_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enq_valid(enq_valid),
    .enq_dest(enq_dest), .enq_delay(enq_delay), .enq_value(enq_value),
    .enq_bit(enq_bit), .enq_whole(enq_whole), .enq_wide(enq_wide),
    .enq_full(enq_full), .wr_en(wr_en), .wr_dest(wr_dest),
    .wr_mask(wr_mask), .wr_data(wr_data), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got cycles=%0d, expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check_bit(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b, expected %0b", tag, got, exp);
    end
  endtask

  task automatic check_wr(input logic en, input logic [ID_W-1:0] d,
                          input logic [63:0] m, input logic [63:0] v, input string tag);
    checks++;
    if (wr_en !== en || (en && (wr_dest !== d || wr_mask !== m || wr_data !== v))) begin
      fails++;
      $display("FAIL %s: got en=%0b dest=%0d mask=%h data=%h, expected en=%0b dest=%0d mask=%h data=%h",
               tag, wr_en, wr_dest, wr_mask, wr_data, en, d, m, v);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic push(input int d, input int dly, input logic [63:0] v,
                      input int b, input logic whole, input logic wide);
    enq_valid = 1'b1;
    enq_dest  = ID_W'(d);
    enq_delay = DLY_W'(dly);
    enq_value = v;
    enq_bit   = 6'(b);
    enq_whole = whole;
    enq_wide  = wide;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_bit(enq_full, 1'b0, "R1 full after reset");
    check_wr(1'b0, '0, '0, '0, "R1 no write after reset");
    check_bit(err, 1'b0, "R1 err after reset");

    // R4 R5 R7 R11 sweep of bit index, width and set/clear
    for (int wide = 0; wide < 2; wide++) begin
      for (int b = 0; b < 64; b++) begin
        for (int s = 0; s < 2; s++) begin
          logic [63:0] m, v;
          m = 64'd1 << (wide != 0 ? b : b % 32);
          v = (s != 0) ? (64'd1 << ((b * 7) % 64)) : 64'd0;
          push(b % 32, 1, v, b, 1'b0, wide[0]);
          pulse_tick();
          check_wr(1'b1, ID_W'(b % 32), m, (s != 0) ? m : 64'd0,
                   s != 0 ? "R4 R7 R11 bit set" : "R5 R7 bit clear");
          step();
          check_wr(1'b0, '0, '0, '0, "R9 applied once");
        end
      end
    end

    // R6 whole writes
    for (int p = 0; p < 6; p++) begin
      for (int wide = 0; wide < 2; wide++) begin
        logic [63:0] v;
        v = 64'hA5C3_0F96_1E2D_7B48 ^ (64'h1111_1111_1111_1111 * p) ^ (64'd1 << (p * 11));
        push(p + 3, 1, v, 63, 1'b1, wide[0]);
        pulse_tick();
        check_wr(1'b1, ID_W'(p + 3), wide != 0 ? '1 : 64'h0000_0000_FFFF_FFFF,
                 wide != 0 ? v : {32'd0, v[31:0]}, "R6 whole write");
        step();
      end
    end

    // R3 countdown timing, delay 0 behaves as 1, idle cycles do not count
    for (int d = 0; d < 7; d++) begin
      int n;
      n = (d == 0) ? 1 : d;
      push(d, d, 64'd1, 2, 1'b0, 1'b1);
      for (int t = 1; t <= n; t++) begin
        step();
        check_wr(1'b0, '0, '0, '0, "R3 no tick no count");
        pulse_tick();
        if (t < n) check_wr(1'b0, '0, '0, '0, "R3 early");
        else check_wr(1'b1, ID_W'(d), 64'd4, 64'd4, "R3 expiry cycle");
      end
      step();
    end

    // R2 R8 R9 out-of-order expiry behind a slow head
    push(1, 3, 64'd1, 0, 1'b0, 1'b1);
    push(2, 1, 64'd1, 1, 1'b0, 1'b1);
    push(3, 1, 64'd1, 2, 1'b0, 1'b1);
    push(4, 2, 64'd1, 3, 1'b0, 1'b1);
    check_bit(enq_full, 1'b1, "R2 full at SLOTS");
    push(9, 1, 64'd1, 9, 1'b0, 1'b1);
    check_bit(enq_full, 1'b1, "R2 still full after dropped push");
    pulse_tick();
    check_wr(1'b1, 5'd2, 64'd2, 64'd2, "R8 first expired in order");
    step();
    check_wr(1'b1, 5'd3, 64'd4, 64'd4, "R8 second expired in order");
    step();
    check_wr(1'b0, '0, '0, '0, "R9 no repeat behind head");
    check_bit(enq_full, 1'b1, "R9 slot kept until head retires");
    pulse_tick();
    check_wr(1'b1, 5'd4, 64'd8, 64'd8, "R8 third");
    step();
    check_wr(1'b0, '0, '0, '0, "R2 R9 idle");
    pulse_tick();
    check_wr(1'b1, 5'd1, 64'd1, 64'd1, "R8 head last");
    step();
    check_bit(enq_full, 1'b0, "R9 head retired frees slot");
    step(); step(); step();
    check_wr(1'b0, '0, '0, '0, "R2 R9 no stray write");
    pulse_tick();
    check_wr(1'b0, '0, '0, '0, "R2 dropped push never lands");
    check_bit(err, 1'b0, "R10 err empty");

    // R8 R10 refill across wrap, simultaneous expiry
    for (int i = 0; i < SLOTS; i++) push(10 + i, 1, 64'd0, i, 1'b0, 1'b0);
    check_bit(enq_full, 1'b1, "R2 full after wrap");
    pulse_tick();
    for (int i = 0; i < SLOTS; i++) begin
      check_wr(1'b1, ID_W'(10 + i), 64'd1 << i, 64'd0, "R8 simultaneous order");
      step();
    end
    check_wr(1'b0, '0, '0, '0, "R9 drained");
    check_bit(enq_full, 1'b0, "R9 empty after drain");
    check_bit(err, 1'b0, "R10 err after wrap");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule